// File: doc/BRIEF.md
# Banked Interrupt Status and Mask Controller

This block gathers interrupt requests from peripherals into three banks of sticky status bits: two banks that feed the normal interrupt line and one bank that feeds the fast interrupt line. Each bank pairs an 8-bit status register with an 8-bit enable mask. A bank is pending when any status bit is set whose mask bit is also set. The normal interrupt output is the OR of the two normal banks' pending terms. The fast interrupt output follows only the fast bank.

Peripherals set status bits with one-cycle request strobes. They clear bits in the second normal bank and in the fast bank with clear strobes. A dedicated strobe, issued when a new audio buffer start address is loaded, clears the buffer-empty bit of the second normal bank. Software uses a small register bus with a write port and a separate read port. Through it, software loads the three masks and clears bits of the first normal bank by writing ones. Writing a mask with bit 7 set also plants a forced trap bit in that bank's status, on the first normal bank and on the fast bank.

Both outputs are level signals decoded from the current registers. Any set, clear or mask write therefore takes effect on the line right after the clock edge that stores it.

Top module: `irq_bank_ctrl`

## Requirements
- R1: A request strobe ORs its pattern into that bank's status register at the next clock edge. Status bits then stay set until a clear removes them.
- R2: `irq_o` is high exactly when (status A AND mask A) or (status B AND mask B) is non-zero. It drops in the cycle after the last enabled pending bit goes away.
- R3: `fiq_o` is high exactly when (fast status AND fast mask) is non-zero. The fast bank never affects `irq_o`, and banks A and B never affect `fiq_o`.
- R4: A write to a mask register (address 1 = mask A, 3 = mask B, 5 = fast mask) stores only bits 7:0 of `wr_data`. The read port returns status A, mask A, status B, mask B, fast status and fast mask at addresses 0 to 5, zero-extended.
- R5: A write to mask A with bit 7 set also sets bit 7 of status A. With bit 7 clear, the write adds no status bit, and the output is re-evaluated against the new mask.
- R6: A write to the fast mask with bit 7 set also sets bit 7 of the fast status, and `fiq_o` is re-evaluated.
- R7: A write to address 0 clears every status A bit written as 1. `irq_o` stays high if other enabled bits remain.
- R8: A write to mask B takes effect on `irq_o` in the next cycle, so unmasking an already pending bit raises the interrupt.
- R9: The clear strobes for bank B and the fast bank remove the selected status bits. The matching output drops when no enabled bit remains.
- R10: `snd_start` clears status B bit 1 only and leaves the other bank B bits unchanged.
- R11: During synchronous reset (`rst_n` low at a clock edge), all status and mask registers become zero and both outputs are low.
- R12: When a set and a clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_a | input | 8 | Request strobes into status A |
| req_b | input | 8 | Request strobes into status B |
| req_f | input | 8 | Request strobes into fast status |
| clr_b | input | 8 | Clear strobes for status B |
| clr_f | input | 8 | Clear strobes for fast status |
| snd_start | input | 1 | Audio buffer start loaded; clears status B bit 1 |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data; only bits 7:0 are used |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, zero-extended |
| irq_o | output | 1 | Normal interrupt level |
| fiq_o | output | 1 | Fast interrupt level |

## Verification
The assertions take for granted that every input is a known value from the first clock edge with reset low. They also assume that the only ways to raise or drop an output are request strobes, clear strobes, mask writes and the bank A clear address, with no unlisted write address aliasing onto a mask. The stimulus changes inputs only on the falling clock edge and holds each strobe and write for exactly one cycle. It holds reset low for several edges before any traffic. Every case that mixes a set and a clear on one bit is presented as a single deliberate cycle, so its expected result is unambiguous.

// File: rtl/irqc_pkg.sv
// Shared constants for the banked interrupt controller.
// Assumes an 8-bit register file reached through a 3-bit address.
package irqc_pkg;
    localparam int ADDR_W = 3;

    // Register addresses; read and write share the numbering.
    localparam logic [ADDR_W-1:0] RA_STAT_A = 3'd0; // read status A / write-one-to-clear A
    localparam logic [ADDR_W-1:0] RA_MASK_A = 3'd1;
    localparam logic [ADDR_W-1:0] RA_STAT_B = 3'd2;
    localparam logic [ADDR_W-1:0] RA_MASK_B = 3'd3;
    localparam logic [ADDR_W-1:0] RA_STAT_F = 3'd4;
    localparam logic [ADDR_W-1:0] RA_MASK_F = 3'd5;

    // Index of each bank in the mask-write enable vector.
    typedef enum logic [1:0] {
        BANK_A = 2'd0,
        BANK_B = 2'd1,
        BANK_F = 2'd2
    } irqc_bank_e;
endpackage

// File: rtl/irqc_bank.sv
// One status/mask bank. Status bits are sticky: set strobes OR in,
// clear strobes AND out, and a set beats a clear on the same bit.
// When HAS_FORCE is set, a mask write with bit FORCE_BIT high also
// sets that status bit. Assumes set/clear inputs are one-cycle strobes.
module irqc_bank #(
    parameter int W         = 8,
    parameter bit HAS_FORCE = 1'b0,
    parameter int FORCE_BIT = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         pending
);
    logic [W-1:0] force_vec;

    generate
        if (HAS_FORCE) begin : g_force
            // Forced trap bit derived from the mask write.
            always_comb begin
                force_vec            = '0;
                force_vec[FORCE_BIT] = mask_we & mask_wdata[FORCE_BIT];
            end

            AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                (mask_we && mask_wdata[FORCE_BIT]) |=> status[FORCE_BIT]); // R5, R6
        end else begin : g_noforce
            assign force_vec = '0;
        end
    endgenerate

    // Status register: clear first, then sets, so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec | force_vec;
    end

    // Mask register: loaded whole on a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    // Bank pending term: any enabled status bit.
    assign pending = |(status & mask);

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec))); // R1
    AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status & ~clr_vec)) == $past(status & ~clr_vec))); // R1
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & clr_vec)) |=> ((status & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec))); // R12
    AST_MASK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask == $past(mask_wdata))); // R4
endmodule

// File: rtl/irqc_regif.sv
// Register bus decode: turns writes into the bank A clear vector and
// per-bank mask-write enables, and muxes the read port.
// Assumes BUS_W > W; upper write bits are discarded.
module irqc_regif #(
    parameter int W     = 8,
    parameter int BUS_W = 32
) (
    input  logic                      wr_en,
    input  logic [irqc_pkg::ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]          wr_data,
    input  logic [irqc_pkg::ADDR_W-1:0] rd_addr,
    input  logic [W-1:0]              stat_a,
    input  logic [W-1:0]              mask_a,
    input  logic [W-1:0]              stat_b,
    input  logic [W-1:0]              mask_b,
    input  logic [W-1:0]              stat_f,
    input  logic [W-1:0]              mask_f,
    output logic [W-1:0]              clr_a_vec,
    output logic [2:0]                mask_we,
    output logic [W-1:0]              mask_wdata,
    output logic [BUS_W-1:0]          rd_data
);
    import irqc_pkg::*;

    logic [W-1:0] rd_byte;
    logic         unused_hi;

    assign unused_hi  = ^wr_data[BUS_W-1:W];
    assign mask_wdata = wr_data[W-1:0];

    // Write decode: clear vector for bank A and mask enables.
    always_comb begin
        clr_a_vec       = '0;
        mask_we         = '0;
        if (wr_en) begin
            if (wr_addr == RA_STAT_A) clr_a_vec = wr_data[W-1:0];
            mask_we[BANK_A] = (wr_addr == RA_MASK_A);
            mask_we[BANK_B] = (wr_addr == RA_MASK_B);
            mask_we[BANK_F] = (wr_addr == RA_MASK_F);
        end
    end

    // Read mux over the six registers.
    always_comb begin
        case (rd_addr)
            RA_STAT_A: rd_byte = stat_a;
            RA_MASK_A: rd_byte = mask_a;
            RA_STAT_B: rd_byte = stat_b;
            RA_MASK_B: rd_byte = mask_b;
            RA_STAT_F: rd_byte = stat_f;
            RA_MASK_F: rd_byte = mask_f;
            default:   rd_byte = '0;
        endcase
    end

    assign rd_data = {{(BUS_W-W){1'b0}}, rd_byte};
endmodule

// File: rtl/irq_bank_ctrl.sv
// Top of the banked interrupt controller: two normal banks feeding
// irq_o, one fast bank feeding fiq_o. Outputs are decoded directly
// from the registers. Assumes all inputs are synchronous to clk.
module irq_bank_ctrl #(
    parameter int W         = 8,
    parameter int BUS_W     = 32,
    parameter int FORCE_BIT = 7,
    parameter int SND_BIT   = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [W-1:0]                req_a,
    input  logic [W-1:0]                req_b,
    input  logic [W-1:0]                req_f,
    input  logic [W-1:0]                clr_b,
    input  logic [W-1:0]                clr_f,
    input  logic                        snd_start,
    input  logic                        wr_en,
    input  logic [irqc_pkg::ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]            wr_data,
    input  logic [irqc_pkg::ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]            rd_data,
    output logic                        irq_o,
    output logic                        fiq_o
);
    import irqc_pkg::*;

    localparam logic [W-1:0] SND_MASK = W'(1) << SND_BIT;

    logic [W-1:0] stat_a, mask_a, stat_b, mask_b, stat_f, mask_f;
    logic [W-1:0] clr_a_vec, clr_b_vec, mask_wdata;
    logic [2:0]   mask_we;
    logic         pend_a, pend_b, pend_f;

    // Bank B clear: peripheral strobes plus the audio-start bit.
    assign clr_b_vec = clr_b | (snd_start ? SND_MASK : '0);

    irqc_regif #(.W(W), .BUS_W(BUS_W)) regif_i (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .stat_a(stat_a), .mask_a(mask_a), .stat_b(stat_b), .mask_b(mask_b),
        .stat_f(stat_f), .mask_f(mask_f),
        .clr_a_vec(clr_a_vec), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .rd_data(rd_data)
    );

    irqc_bank #(.W(W), .HAS_FORCE(1'b1), .FORCE_BIT(FORCE_BIT)) bank_a_i (
        .clk(clk), .rst_n(rst_n), .set_vec(req_a), .clr_vec(clr_a_vec),
        .mask_we(mask_we[BANK_A]), .mask_wdata(mask_wdata),
        .status(stat_a), .mask(mask_a), .pending(pend_a)
    );

    irqc_bank #(.W(W), .HAS_FORCE(1'b0), .FORCE_BIT(FORCE_BIT)) bank_b_i (
        .clk(clk), .rst_n(rst_n), .set_vec(req_b), .clr_vec(clr_b_vec),
        .mask_we(mask_we[BANK_B]), .mask_wdata(mask_wdata),
        .status(stat_b), .mask(mask_b), .pending(pend_b)
    );

    irqc_bank #(.W(W), .HAS_FORCE(1'b1), .FORCE_BIT(FORCE_BIT)) bank_f_i (
        .clk(clk), .rst_n(rst_n), .set_vec(req_f), .clr_vec(clr_f),
        .mask_we(mask_we[BANK_F]), .mask_wdata(mask_wdata),
        .status(stat_f), .mask(mask_f), .pending(pend_f)
    );

    // Output levels toward the CPU.
    assign irq_o = pend_a | pend_b;
    assign fiq_o = pend_f;

    AST_RST_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !fiq_o)); // R11
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((|req_a) || (|req_b) ||
            (wr_en && (wr_addr == RA_MASK_A || wr_addr == RA_MASK_B)))); // R2
    AST_FIQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_o) |-> $past((|req_f) || (wr_en && wr_addr == RA_MASK_F))); // R3
    AST_FIQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fiq_o) |-> $past((|clr_f) || (wr_en && wr_addr == RA_MASK_F))); // R9
endmodule

// File: tb/irq_bank_ctrl_tb_top.sv
// Scoreboard bench: the driver task applies one cycle of stimulus,
// updates a model built from the requirements and queues the expected
// outputs; the monitor pops and compares shortly after each edge.
module irq_bank_ctrl_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req_a = '0, req_b = '0, req_f = '0, clr_b = '0, clr_f = '0;
    logic        snd_start = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o, fiq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_sa = '0, m_ma = '0, m_sb = '0, m_mb = '0, m_sf = '0, m_mf = '0;

    logic        q_irq[$];
    logic        q_fiq[$];
    logic [31:0] q_rd[$];
    string       q_tag[$];

    always #(CLK_P/2) clk = ~clk;

    irq_bank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b), .req_f(req_f),
        .clr_b(clr_b), .clr_f(clr_f), .snd_start(snd_start), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_sa;
            3'd1: return m_ma;
            3'd2: return m_sb;
            3'd3: return m_mb;
            3'd4: return m_sf;
            3'd5: return m_mf;
            default: return 8'h00;
        endcase
    endfunction

    // Driver: one cycle of stimulus, model update, expected item pushed.
    task automatic drive(input logic [7:0] ra, input logic [7:0] rb, input logic [7:0] rf,
                         input logic [7:0] cb, input logic [7:0] cf, input logic snd,
                         input logic we, input logic [2:0] wa, input logic [31:0] wd,
                         input logic [2:0] rda, input string tag);
        logic [7:0] clr_a_m;
        logic [7:0] frc_a, frc_f;
        @(negedge clk);
        req_a = ra; req_b = rb; req_f = rf; clr_b = cb; clr_f = cf;
        snd_start = snd; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = rda;
        clr_a_m = (we && wa == 3'd0) ? wd[7:0] : 8'h00;
        frc_a   = (we && wa == 3'd1 && wd[7]) ? 8'h80 : 8'h00;
        frc_f   = (we && wa == 3'd5 && wd[7]) ? 8'h80 : 8'h00;
        m_sa = (m_sa & ~clr_a_m) | ra | frc_a;
        m_sb = (m_sb & ~(cb | (snd ? 8'h02 : 8'h00))) | rb;
        m_sf = (m_sf & ~cf) | rf | frc_f;
        if (we && wa == 3'd1) m_ma = wd[7:0];
        if (we && wa == 3'd3) m_mb = wd[7:0];
        if (we && wa == 3'd5) m_mf = wd[7:0];
        @(posedge clk);
        #1;
        req_a = '0; req_b = '0; req_f = '0; clr_b = '0; clr_f = '0;
        snd_start = 1'b0; wr_en = 1'b0;
        q_irq.push_back(((m_sa & m_ma) != 0) || ((m_sb & m_mb) != 0));
        q_fiq.push_back((m_sf & m_mf) != 0);
        q_rd.push_back({24'h0, model_read(rda)});
        q_tag.push_back(tag);
    endtask

    task automatic idle(input logic [2:0] rda, input string tag);
        drive(0, 0, 0, 0, 0, 1'b0, 1'b0, 3'd0, 32'h0, rda, tag);
    endtask

    task automatic wr(input logic [2:0] wa, input logic [31:0] wd, input logic [2:0] rda, input string tag);
        drive(0, 0, 0, 0, 0, 1'b0, 1'b1, wa, wd, rda, tag);
    endtask

    // Monitor: compare outputs a little after each rising edge.
    always @(posedge clk) begin
        #3;
        if (q_tag.size() > 0) begin
            string t;
            t = q_tag.pop_front();
            chk(t, "irq_o", {31'h0, irq_o}, {31'h0, q_irq.pop_front()});
            chk(t, "fiq_o", {31'h0, fiq_o}, {31'h0, q_fiq.pop_front()});
            chk(t, "rd_data", rd_data, q_rd.pop_front());
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: everything reads zero after reset
        for (int a = 0; a < 6; a++) idle(3'(a), "R11 reset state");

        // R1: request latches, masked so no interrupt, and stays set
        drive(8'h05, 0, 0, 0, 0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd0, "R1 set A");
        idle(3'd0, "R1 sticky A");
        // R4: only the low byte of a mask write is kept
        wr(3'd1, 32'h1234_5604, 3'd1, "R4 mask A low byte");
        idle(3'd0, "R2 irq from bank A");
        wr(3'd1, 32'h0000_0005, 3'd1, "R4 mask A rewrite");
        // R7: clearing one enabled bit keeps irq while another remains
        wr(3'd0, 32'h0000_0004, 3'd0, "R7 partial clear A");
        wr(3'd0, 32'h0000_0001, 3'd0, "R2 irq drops when A empty");
        // R5: bit 7 of a mask A write forces status bit 7
        wr(3'd1, 32'h0000_0080, 3'd0, "R5 force A");
        wr(3'd0, 32'h0000_0080, 3'd0, "R7 clear forced bit");
        wr(3'd1, 32'h0000_007F, 3'd0, "R5 no force without bit 7");
        wr(3'd1, 32'h0000_0000, 3'd1, "R4 mask A zero");

        // R8: unmasking a pending bank B bit raises irq
        drive(0, 8'h10, 0, 0, 0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd2, "R1 set B masked");
        wr(3'd3, 32'h0000_0012, 3'd3, "R8 unmask B");
        drive(0, 0, 0, 8'h10, 0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd2, "R9 clear B drops irq");
        // R10: audio start clears only bit 1 of bank B
        drive(0, 8'h02, 0, 0, 0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd2, "R2 irq from bank B");
        drive(0, 0, 0, 0, 0, 1'b1, 1'b0, 3'd0, 32'h0, 3'd2, "R10 snd clears bit1");
        drive(0, 8'h06, 0, 0, 0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd2, "R2 B bits 1,2");
        drive(0, 0, 0, 0, 0, 1'b1, 1'b0, 3'd0, 32'h0, 3'd2, "R10 other bits kept");

        // R3: fast bank drives only fiq_o
        drive(0, 0, 8'h01, 0, 0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd4, "R3 set F masked");
        wr(3'd5, 32'h0000_0001, 3'd5, "R3 fiq only from F");
        // R6: bit 7 of fast mask write forces fast status bit 7
        wr(3'd5, 32'hFFFF_FF81, 3'd4, "R6 force F");
        drive(0, 0, 0, 0, 8'h01, 1'b0, 1'b0, 3'd0, 32'h0, 3'd4, "R9 partial clear F");
        drive(0, 0, 0, 0, 8'h80, 1'b0, 1'b0, 3'd0, 32'h0, 3'd4, "R9 clear F drops fiq");
        // R3: bank A pending does not reach fiq_o
        wr(3'd1, 32'h0000_0008, 3'd1, "R3 mask A only");
        drive(8'h08, 0, 0, 0, 0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd0, "R3 irq without fiq");

        // R12: set and clear on the same bit in the same cycle
        drive(0, 8'h20, 0, 8'h20, 0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd2, "R12 set beats clr B");
        drive(8'h08, 0, 0, 0, 0, 1'b0, 1'b1, 3'd0, 32'h0000_0008, 3'd0, "R12 set beats W1C A");
        drive(0, 0, 8'h40, 0, 8'h40, 1'b0, 1'b0, 3'd0, 32'h0, 3'd4, "R12 set beats clr F");

        // R11: reset mid-run returns to zero
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #3;
        chk("R11 reset mid-run", "irq_o", {31'h0, irq_o}, 32'h0);
        chk("R11 reset mid-run", "fiq_o", {31'h0, fiq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        m_sa = '0; m_ma = '0; m_sb = '0; m_mb = '0; m_sf = '0; m_mf = '0;
        idle(3'd2, "R11 status B cleared");
        idle(3'd5, "R11 mask F cleared");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule